// File: doc/BRIEF.md
# Serial CRC Long-Division Register

This block divides a serial bit stream, modulo 2, by a generator polynomial of degree `R`. It holds an `R`-stage remainder register. The generator's leading term is implicit, so only its `R` low-order coefficients are given, through the `POLY` parameter. On each accepted bit the register moves one place toward its top stage and the new bit enters the bottom. The bit that leaves the top decides whether the polynomial's low-order coefficients are XORed into the shifted value. At every step the register therefore holds the bits received so far, reduced modulo the generator.

The block has two uses.
- **Generation.** Feed a message, then raise `flush`. The first `R` flush strobes append zero bits. The register then holds the check bits.
- **Checking.** Feed a received message with its check bits attached. A zero remainder, shown on `rem_zero`, means no error was seen.

After the augmenting strobes, `R` more flush strobes shift the check bits out of the top stage on `ser_out`, most significant bit first. A one-cycle `done` pulse follows the last of these strobes. An elaboration check rejects any `POLY` whose constant coefficient is 0.

Top module: `crc_serial_div`

## Requirements
- R1: After reset, `rem` is all zeros and `rem_zero` is 1.
- R2: On a cycle with `bit_vld` high, `flush` low and `rem[R-1]` equal to 0, the next `rem` is `{rem[R-2:0], bit_in}`.
- R3: On a cycle with `bit_vld` high, `flush` low and `rem[R-1]` equal to 1, the next `rem` is `{rem[R-2:0], bit_in} ^ POLY`, where bit k of `POLY` is the coefficient of x^k.
- R4: `rem_zero` is 1 exactly when `rem` is all zeros. Feeding a message followed by its check bits (MSB first) leaves a zero remainder, while a single flipped bit leaves a nonzero one. With `R`=3 and `POLY`=3'b001 (x^3+1), every frame that is zero except for two adjacent 1 bits leaves a nonzero remainder.
- R5: A cycle with `bit_vld` low and `clr` low leaves `rem` unchanged.
- R6: `clr` zeroes `rem` and the flush count, and it overrides `bit_vld` on the same cycle.
- R7: While `flush` is high, `bit_in` is ignored and a 0 is shifted in. After a message, the first `R` flush strobes leave the message's check bits in `rem`.
- R8: The flush strobes numbered `R`+1 to 2`R` shift with no XOR, so the value on `ser_out` before each one is the next check bit, MSB first. `done` is high for exactly the one cycle after the 2`R`-th flush strobe, and `rem` is then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the remainder and flush count |
| bit_in | input | 1 | Serial message bit |
| bit_vld | input | 1 | Accept one bit on this clock edge |
| flush | input | 1 | Accepted bits are zeros of the flush phase |
| rem | output | R | Current remainder |
| rem_zero | output | 1 | Remainder is all zeros |
| ser_out | output | 1 | Top stage, serial read-out of the remainder |
| done | output | 1 | One-cycle pulse when the read-out is complete |

## Verification
The 16-bit instance is driven with several message patterns: all zeros, all ones, alternating bits and random words of mixed lengths.
- **All-zero message.** Never raises the top stage, so only the plain shift of R2 is tried.
- **All-ones and alternating messages.** Force the XOR path of R3 on most steps.
- **Random messages with idle gaps and toggling `bit_in` during flush.** Separate true hold and ignore behaviour (R5, R7) from accidental matches.

Each generated check value is fed back after its message to confirm a zero remainder, and then with one bit flipped to confirm detection. A 3-stage x^3+1 instance is swept over every adjacent two-bit error position, which sets the double-error case apart from the exact multiple x^3+1, whose remainder is zero.

// File: rtl/crc_serial_div.sv
module crc_serial_div #(
  parameter int           R    = 16,
  parameter logic [R-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_in,
  input  logic         bit_vld,
  input  logic         flush,
  output logic [R-1:0] rem,
  output logic         rem_zero,
  output logic         ser_out,
  output logic         done
);
  localparam int CW = $clog2(2 * R + 1);
  localparam logic [CW-1:0] AUG_END  = CW'(R);
  localparam logic [CW-1:0] LAST_CNT = CW'(2 * R - 1);

  if (!POLY[0]) begin : g_bad_poly
    $error("crc_serial_div: POLY needs a constant term of 1");
  end
  if (R < 2) begin : g_bad_deg
    $error("crc_serial_div: R must be at least 2");
  end

  logic [R-1:0]  rem_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  wire           readout = flush && (cnt_q >= AUG_END);
  wire           din     = flush ? 1'b0 : bit_in;
  wire           fb      = rem_q[R-1] && !readout;
  wire [R-1:0]   nxt     = {rem_q[R-2:0], din} ^ (fb ? POLY : '0);
  wire           last    = flush && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= bit_vld && last;
      if (bit_vld) begin
        rem_q <= nxt;
        if (flush) cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign rem      = rem_q;
  assign rem_zero = (rem_q == '0);
  assign ser_out  = rem_q[R-1];
  assign done     = done_q;
endmodule

// File: rtl/crc_serial_div_chk.sv
module crc_serial_div_chk #(
  parameter int           R    = 16,
  parameter logic [R-1:0] POLY = 16'h1021
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         bit_in,
  input logic         bit_vld,
  input logic         flush,
  input logic [R-1:0] rem,
  input logic         rem_zero,
  input logic         ser_out,
  input logic         done
);
  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !clr && !flush && !rem[R-1]) |=> rem == {$past(rem[R-2:0]), $past(bit_in)}); // R2
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !clr && !flush && rem[R-1]) |=> rem == ({$past(rem[R-2:0]), $past(bit_in)} ^ POLY)); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rem_zero == (rem == '0)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> $stable(rem)); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem == '0 && !done)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bit_vld && flush) && rem == '0 && !ser_out)); // R8
endmodule

bind crc_serial_div crc_serial_div_chk #(.R(R), .POLY(POLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_vld(bit_vld),
  .flush(flush), .rem(rem), .rem_zero(rem_zero), .ser_out(ser_out), .done(done)
);

// File: tb/tb_crc_serial_div.sv
module tb_crc_serial_div;
  localparam int           R = 16;
  localparam logic [R-1:0] P = 16'h1021;

  typedef struct {
    int           due;
    logic [R-1:0] rem;
    logic         dn;
    string        req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, bit_in = 1'b0, bit_vld = 1'b0, flush = 1'b0;
  logic [R-1:0] rem;
  logic rem_zero, ser_out, done;

  logic clr3 = 1'b0, b3 = 1'b0, v3 = 1'b0;
  logic [2:0] rem3;
  logic z3, s3, d3;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  exp_t sbq[$];
  exp_t mon_e;
  logic [R-1:0] mrem = '0;
  int mcnt = 0;
  logic last_ser;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crc_serial_div #(.R(R), .POLY(P)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_vld(bit_vld),
    .flush(flush), .rem(rem), .rem_zero(rem_zero), .ser_out(ser_out), .done(done));

  crc_serial_div #(.R(3), .POLY(3'b001)) dut3 (
    .clk(clk), .rst_n(rst_n), .clr(clr3), .bit_in(b3), .bit_vld(v3),
    .flush(1'b0), .rem(rem3), .rem_zero(z3), .ser_out(s3), .done(d3));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      mon_e = sbq.pop_front();
      chk(rem == mon_e.rem, mon_e.req, "rem", 32'(rem), 32'(mon_e.rem));
      chk(rem_zero == (mon_e.rem == '0), "R4", "rem_zero", 32'(rem_zero), 32'(mon_e.rem == '0));
      chk(done == mon_e.dn, mon_e.req, "done", 32'(done), 32'(mon_e.dn));
    end
  end

  task automatic drive(input logic v, input logic b, input logic fl, input logic c, input string req);
    logic dn;
    logic fb;
    logic feed;
    @(negedge clk);
    last_ser = ser_out;
    bit_vld = v; bit_in = b; flush = fl; clr = c;
    dn = 1'b0;
    if (c) begin
      mrem = '0; mcnt = 0;
    end else if (v) begin
      feed = fl ? 1'b0 : b;
      fb = mrem[R-1] && !(fl && mcnt >= R);
      mrem = {mrem[R-2:0], feed} ^ (fb ? P : '0);
      if (fl) begin
        dn = (mcnt == 2 * R - 1);
        mcnt = dn ? 0 : mcnt + 1;
      end
    end
    sbq.push_back('{due: cyc + 1, rem: mrem, dn: dn, req: req});
    @(posedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'($urandom), 1'b0, 1'b0, "R5");
  endtask

  task automatic run_msg(input logic [63:0] msg, input int len, input bit gaps);
    logic [R-1:0] crc;
    drive(1'b1, 1'b1, 1'b0, 1'b1, "R6");
    for (int i = len - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) idle();
      drive(1'b1, msg[i], 1'b0, 1'b0, "R2 R3");
    end
    for (int k = 0; k < R; k++) drive(1'b1, 1'($urandom), 1'b1, 1'b0, "R7");
    crc = mrem;
    for (int k = 0; k < R; k++) begin
      drive(1'b1, 1'($urandom), 1'b1, 1'b0, "R8");
      chk(last_ser == crc[R-1-k], "R8", "ser_out", 32'(last_ser), 32'(crc[R-1-k]));
    end
    idle();
    drive(1'b0, 1'b0, 1'b0, 1'b1, "R6");
    for (int i = len - 1; i >= 0; i--) drive(1'b1, msg[i], 1'b0, 1'b0, "R4");
    for (int i = R - 1; i >= 0; i--) drive(1'b1, crc[i], 1'b0, 1'b0, "R4");
    idle();
    @(negedge clk);
    chk(rem_zero == 1'b1, "R4", "check zero", 32'(rem_zero), 32'd1);
    begin
      int fp;
      fp = $urandom % (len + R);
      drive(1'b0, 1'b0, 1'b0, 1'b1, "R6");
      for (int i = len + R - 1; i >= 0; i--) begin
        logic bb;
        bb = (i >= R) ? msg[i - R] : crc[i];
        drive(1'b1, bb ^ (i == fp), 1'b0, 1'b0, "R4");
      end
      idle();
      @(negedge clk);
      chk(rem_zero == 1'b0, "R4", "corrupt detect", 32'(rem_zero), 32'd0);
    end
  endtask

  task automatic feed3(input logic [11:0] frame);
    @(negedge clk); clr3 = 1'b1; v3 = 1'b0;
    @(negedge clk); clr3 = 1'b0;
    for (int i = 11; i >= 0; i--) begin
      v3 = 1'b1; b3 = frame[i];
      @(negedge clk);
    end
    v3 = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rem == '0, "R1", "reset rem", 32'(rem), 32'd0);
    chk(rem_zero == 1'b1, "R1", "reset flag", 32'(rem_zero), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rem == '0 && rem_zero, "R1", "after reset", 32'(rem), 32'd0);

    run_msg(64'h0, 16, 1'b0);
    run_msg(64'hFFFF_FFFF, 32, 1'b0);
    run_msg(64'hAAAA_AAAA_AAAA, 48, 1'b1);
    for (int n = 0; n < 6; n++)
      run_msg({$urandom, $urandom}, 8 + int'($urandom % 57), 1'b1);

    drive(1'b1, 1'b1, 1'b0, 1'b0, "R2 R3");
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R2 R3");
    drive(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    drive(1'b1, 1'b1, 1'b0, 1'b1, "R6");
    idle();
    @(negedge clk);
    chk(rem == '0, "R6", "clear beats valid", 32'(rem), 32'd0);

    feed3(12'b0000_0000_1001);
    chk(z3 == 1'b1, "R4", "x3+1 itself", 32'(rem3), 32'd0);
    for (int i = 0; i < 11; i++) begin
      feed3(12'(2'b11) << i);
      chk(z3 == 1'b0, "R4", "adjacent pair", 32'(rem3), 32'hFFFF_FFFF);
    end

    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R5", "scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule